// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host-facing pins of a parallel flash device. It watches host write cycles and works out which command the host is issuing. It tracks the standard unlock handshake, the erase setup byte and the final erase command. From these it raises a one-cycle start pulse for a whole-array erase or a single-sector erase, which goes to the erase engine. While the device is in identification mode, it also supplies the fixed manufacturer and device codes on the read path.

All pins are sampled synchronously in the block's clock domain. A host write takes effect when the write strobe rises while chip select is low. The erase engine reports back through a done input and a failure input. A parameter picks between the top-boot and bottom-boot device code.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read), both start pulses are low and `id_data` is 0.
- R2: A write is accepted only on a rising edge of `we_n` seen while `cs_n` is low. Strobes with `cs_n` high have no effect on `mode` or on the start pulses.
- R3: The unlock pair is data AAh at address 555h, then data 55h at address 2AAh. Only `addr[10:0]` is compared. After one unlock pair, 90h written at 555h sets `mode` to 1 (ID).
- R4: In ID mode, with `cs_n` and `oe_n` low and `addr[1:0]`=00, `id_data` becomes 00C2h one clock later. This holds in both byte and word width.
- R5: In ID mode with `addr[1:0]`=01, `id_data` is the device code. For the top-boot variant this is 22DAh in word width (`word_mode`=1) and 00DAh in byte width. For the bottom-boot variant it is 225Bh and 005Bh. Any other `addr[1:0]` gives 0.
- R6: `id_data` is 0 whenever `mode` is not ID, or `oe_n` or `cs_n` is high.
- R7: Writing F0h in array-read or ID mode leaves `mode` at 0. Array-read mode persists until a command sequence changes it.
- R8: The six writes unlock pair, 80h at 555h, unlock pair, 10h at 555h raise `chip_go` for exactly one clock and set `mode` to 2 (erase busy).
- R9: The same sequence ending in 30h at any address raises `sect_go` for one clock. It also sets `sector_addr` to `addr[AW-1:SEC_LSB]` of that final write, and `mode` to 2.
- R10: A write that breaks an expected sequence returns the decoder to array read, and no start pulse is issued.
- R11: In mode 2, all writes (including F0h) are ignored. `erase_done` returns `mode` to 0.
- R12: In mode 2, `erase_fail` sets `mode` to 3 (failed). There, only an F0h write returns `mode` to 0, and every other write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; command taken on rising edge |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit read width, 0 = 8-bit |
| addr | input | AW | Host address |
| din | input | 8 | Command byte |
| erase_done | input | 1 | Erase engine finished successfully |
| erase_fail | input | 1 | Erase engine reports failure |
| mode | output | 2 | 0 read, 1 ID, 2 erase busy, 3 erase failed |
| chip_go | output | 1 | One-cycle chip-erase start |
| sect_go | output | 1 | One-cycle sector-erase start |
| sector_addr | output | AW-SEC_LSB | Sector of the last sector-erase launch |
| id_data | output | 16 | Identification read data |

## Verification
The assertions assume that `erase_done` and `erase_fail` are only raised while the decoder is in erase-busy mode. They also assume that the host pins are already synchronous to `clk`. The stimulus follows both rules: the erase engine's responses are pulsed only after a start pulse has been observed. Each write holds the strobe low for a full clock and high for at least two before the next one, so every rising edge is seen exactly once.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    S_READ, S_ID, S_U1, S_U2, S_SETUP, S_E1, S_E2, S_BUSY, S_FAIL
  } st_t;

  localparam logic [1:0] MODE_READ = 2'd0;
  localparam logic [1:0] MODE_ID   = 2'd1;
  localparam logic [1:0] MODE_BUSY = 2'd2;
  localparam logic [1:0] MODE_FAIL = 2'd3;

  localparam int unsigned MATCH_W = 11;
  localparam logic [MATCH_W-1:0] ADR_A = 11'h555;
  localparam logic [MATCH_W-1:0] ADR_B = 11'h2AA;

  localparam logic [7:0] K_UNLK1 = 8'hAA;
  localparam logic [7:0] K_UNLK2 = 8'h55;
  localparam logic [7:0] K_IDENT = 8'h90;
  localparam logic [7:0] K_SETUP = 8'h80;
  localparam logic [7:0] K_CHIP  = 8'h10;
  localparam logic [7:0] K_SECT  = 8'h30;
  localparam logic [7:0] K_RESET = 8'hF0;

  localparam logic [15:0] MFR_CODE = 16'h00C2;
endpackage

// File: rtl/fcd_wr_capture.sv
module fcd_wr_capture #(
  parameter int unsigned AW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          wr_vld,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  logic we_q;
  logic rise;

  assign rise = !cs_n && !we_q && we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b1;
      wr_vld  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      we_q   <= we_n;
      wr_vld <= rise;
      if (rise) begin
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int unsigned AW     = 19,
  parameter int unsigned SEC_LSB = 15,
  localparam int unsigned SW    = AW - SEC_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          erase_done,
  input  logic          erase_fail,
  output logic [1:0]    mode,
  output logic          chip_go,
  output logic          sect_go,
  output logic [SW-1:0] sector_addr
);
  st_t  state, nxt;
  logic go_c, go_s;
  logic at_a, is_u1, is_u2;

  assign at_a  = wr_addr[MATCH_W-1:0] == ADR_A;
  assign is_u1 = at_a && wr_data == K_UNLK1;
  assign is_u2 = (wr_addr[MATCH_W-1:0] == ADR_B) && wr_data == K_UNLK2;

  function automatic logic [1:0] mode_of(st_t s);
    case (s)
      S_ID:    return MODE_ID;
      S_BUSY:  return MODE_BUSY;
      S_FAIL:  return MODE_FAIL;
      default: return MODE_READ;
    endcase
  endfunction

  always_comb begin
    nxt  = state;
    go_c = 1'b0;
    go_s = 1'b0;
    case (state)
      S_BUSY: begin
        if (erase_fail)      nxt = S_FAIL;
        else if (erase_done) nxt = S_READ;
      end
      S_FAIL: begin
        if (wr_vld && wr_data == K_RESET) nxt = S_READ;
      end
      default: begin
        if (wr_vld) begin
          nxt = S_READ;
          case (state)
            S_READ, S_ID: if (is_u1) nxt = S_U1;
            S_U1:         if (is_u2) nxt = S_U2;
            S_U2: begin
              if (at_a && wr_data == K_IDENT)      nxt = S_ID;
              else if (at_a && wr_data == K_SETUP) nxt = S_SETUP;
            end
            S_SETUP:      if (is_u1) nxt = S_E1;
            S_E1:         if (is_u2) nxt = S_E2;
            S_E2: begin
              if (at_a && wr_data == K_CHIP) begin
                nxt  = S_BUSY;
                go_c = 1'b1;
              end else if (wr_data == K_SECT) begin
                nxt  = S_BUSY;
                go_s = 1'b1;
              end
            end
            default: nxt = S_READ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_READ;
      mode        <= MODE_READ;
      chip_go     <= 1'b0;
      sect_go     <= 1'b0;
      sector_addr <= '0;
    end else begin
      state   <= nxt;
      mode    <= mode_of(nxt);
      chip_go <= go_c;
      sect_go <= go_s;
      if (go_s) sector_addr <= wr_addr[AW-1:SEC_LSB];
    end
  end
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux
  import fcd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode,
  input  logic        cs_n,
  input  logic        oe_n,
  input  logic        word_mode,
  input  logic [1:0]  sel,
  output logic [15:0] id_data
);
  logic [15:0] dev_word;
  logic [15:0] dev_code;
  logic [15:0] pick;

  if (TOP_BOOT) begin : g_top
    assign dev_word = 16'h22DA;
  end else begin : g_bottom
    assign dev_word = 16'h225B;
  end

  assign dev_code = word_mode ? dev_word : {8'h00, dev_word[7:0]};

  always_comb begin
    case (sel)
      2'b00:   pick = MFR_CODE;
      2'b01:   pick = dev_code;
      default: pick = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) id_data <= '0;
    else if (mode == MODE_ID && !cs_n && !oe_n) id_data <= pick;
    else id_data <= '0;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int unsigned AW       = 19,
  parameter int unsigned SEC_LSB  = 15,
  parameter bit          TOP_BOOT = 1'b1,
  localparam int unsigned SW      = AW - SEC_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          erase_done,
  input  logic          erase_fail,
  output logic [1:0]    mode,
  output logic          chip_go,
  output logic          sect_go,
  output logic [SW-1:0] sector_addr,
  output logic [15:0]   id_data
);
  logic          wr_vld;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  fcd_wr_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .addr(addr), .din(din),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcd_seq #(.AW(AW), .SEC_LSB(SEC_LSB)) u_seq (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .wr_data(wr_data), .erase_done(erase_done), .erase_fail(erase_fail),
    .mode(mode), .chip_go(chip_go), .sect_go(sect_go),
    .sector_addr(sector_addr)
  );

  fcd_id_mux #(.TOP_BOOT(TOP_BOOT)) u_id (
    .clk(clk), .rst(rst), .mode(mode), .cs_n(cs_n), .oe_n(oe_n),
    .word_mode(word_mode), .sel(addr[1:0]), .id_data(id_data)
  );
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  mode,
  input logic        chip_go,
  input logic        sect_go,
  input logic [15:0] id_data,
  input logic        erase_done,
  input logic        erase_fail
);
  // R8
  go_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(chip_go && sect_go));

  // R8
  chip_single_chk: assert property (@(posedge clk) disable iff (rst)
    chip_go |=> !chip_go);

  // R9
  sect_single_chk: assert property (@(posedge clk) disable iff (rst)
    sect_go |=> !sect_go);

  // R8
  go_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_go || sect_go) |-> mode == 2'd2);

  // R10
  go_from_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(chip_go || sect_go) |-> $past(mode) == 2'd0);

  // R6
  id_only_in_id_chk: assert property (@(posedge clk) disable iff (rst)
    (id_data != 16'h0) |-> $past(mode) == 2'd1);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !erase_done && !erase_fail) |=> mode == 2'd2);

  // R12
  fail_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |=> (mode == 2'd3 || mode == 2'd0));
endmodule

bind flash_cmd_decoder fcd_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .chip_go(chip_go), .sect_go(sect_go),
  .id_data(id_data), .erase_done(erase_done), .erase_fail(erase_fail)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int AW = 19;
  localparam int SEC_LSB = 15;
  localparam int SW = AW - SEC_LSB;

  logic clk = 0, rst = 1;
  logic cs_n = 1, we_n = 1, oe_n = 1, word_mode = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic erase_done = 0, erase_fail = 0;
  logic [1:0] mode;
  logic chip_go, sect_go;
  logic [SW-1:0] sector_addr;
  logic [15:0] id_data;

  int checks = 0, errors = 0;
  int chip_cnt = 0, sect_cnt = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .SEC_LSB(SEC_LSB), .TOP_BOOT(1'b1)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .word_mode(word_mode), .addr(addr), .din(din), .erase_done(erase_done),
    .erase_fail(erase_fail), .mode(mode), .chip_go(chip_go), .sect_go(sect_go),
    .sector_addr(sector_addr), .id_data(id_data)
  );

  always @(negedge clk) begin
    if (!rst && chip_go) chip_cnt++;
    if (!rst && sect_go) sect_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Returns at the falling edge after the decoder has updated its state.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic csel_n = 1'b0);
    @(negedge clk);
    cs_n = csel_n; addr = a; din = d; we_n = 0;
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    cs_n = 1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(19'h555, 8'hAA);
    wr(19'h2AA, 8'h55);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic wm, input logic oen);
    @(negedge clk);
    cs_n = 0; oe_n = oen; addr = a; word_mode = wm;
    @(negedge clk);
  endtask

  task automatic pulse_engine(input logic fail);
    @(negedge clk);
    if (fail) erase_fail = 1; else erase_done = 1;
    @(negedge clk);
    erase_fail = 0; erase_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 chip_go", chip_go, 0);
    chk("R1 sect_go", sect_go, 0);
    chk("R1 id_data", id_data, 0);
  endtask

  task automatic t_cs_ignored();
    wr(19'h555, 8'hAA, 1'b1);
    wr(19'h2AA, 8'h55, 1'b1);
    wr(19'h555, 8'h90, 1'b1);
    chk("R2 mode unchanged with cs_n high", mode, 0);
  endtask

  task automatic t_id();
    unlock();
    wr(19'h555, 8'h90);
    chk("R3 id mode", mode, 1);
    rd(19'h0, 1'b1, 1'b0);
    chk("R4 mfr word", id_data, 16'h00C2);
    rd(19'h0, 1'b0, 1'b0);
    chk("R4 mfr byte", id_data, 16'h00C2);
    rd(19'h1, 1'b1, 1'b0);
    chk("R5 dev word", id_data, 16'h22DA);
    rd(19'h1, 1'b0, 1'b0);
    chk("R5 dev byte", id_data, 16'h00DA);
    rd(19'h2, 1'b1, 1'b0);
    chk("R5 other addr", id_data, 0);
    rd(19'h0, 1'b1, 1'b1);
    chk("R6 oe_n high", id_data, 0);
    oe_n = 1; cs_n = 1;
    wr(19'h0, 8'hF0);
    chk("R7 reset leaves id", mode, 0);
    rd(19'h0, 1'b1, 1'b0);
    chk("R6 read mode gives 0", id_data, 0);
    oe_n = 1; cs_n = 1;
    wr(19'h0, 8'hF0);
    chk("R7 reset in read mode", mode, 0);
  endtask

  task automatic t_chip();
    int c0 = chip_cnt;
    unlock(); wr(19'h555, 8'h80); unlock();
    wr(19'h555, 8'h10);
    chk("R8 chip_go pulse", chip_go, 1);
    chk("R8 sect_go low", sect_go, 0);
    chk("R8 busy mode", mode, 2);
    @(negedge clk);
    chk("R8 chip_go one cycle", chip_cnt - c0, 1);
    wr(19'h0, 8'hF0);
    chk("R11 F0 ignored while busy", mode, 2);
    unlock();
    chk("R11 writes ignored while busy", mode, 2);
    pulse_engine(1'b0);
    chk("R11 done returns to read", mode, 0);
  endtask

  task automatic t_sector();
    logic [AW-1:0] sa = 19'h58123;
    int s0 = sect_cnt;
    unlock(); wr(19'h555, 8'h80); unlock();
    wr(sa, 8'h30);
    chk("R9 sect_go pulse", sect_go, 1);
    chk("R9 sector addr", sector_addr, int'(sa >> SEC_LSB));
    chk("R9 busy mode", mode, 2);
    @(negedge clk);
    chk("R9 sect_go one cycle", sect_cnt - s0, 1);
    pulse_engine(1'b0);
    chk("R11 done after sector", mode, 0);
  endtask

  task automatic t_broken();
    int c0 = chip_cnt, s0 = sect_cnt;
    wr(19'h555, 8'hAA);
    wr(19'h123, 8'h55);
    wr(19'h555, 8'h80);
    unlock();
    wr(19'h555, 8'h10);
    chk("R10 bad unlock addr no launch", chip_cnt - c0, 0);
    chk("R10 mode read", mode, 0);
    unlock(); wr(19'h555, 8'h80);
    wr(19'h555, 8'h77);
    wr(19'h2AA, 8'h55);
    wr(19'h555, 8'h30);
    chk("R10 bad second unlock no launch", sect_cnt - s0, 0);
    chk("R10 mode read after break", mode, 0);
  endtask

  task automatic t_fail();
    unlock(); wr(19'h555, 8'h80); unlock();
    wr(19'h555, 8'h10);
    pulse_engine(1'b1);
    chk("R12 failed mode", mode, 3);
    wr(19'h555, 8'hAA);
    chk("R12 other write ignored", mode, 3);
    wr(19'h0, 8'hF0);
    chk("R12 F0 clears failure", mode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cs_ignored();
    t_id();
    t_chip();
    t_sector();
    t_broken();
    t_fail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule